// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block sequences the power states of a small microcontroller. From Run it enters a low-power state when the CPU issues a sleep strobe. If the idle-enable bit is set, that state is Idle: the CPU clock stops and the peripherals keep their clock. If the bit is clear, the state is Sleep and every clock stops. The block owns the idle-enable bit and a two-bit clock-select field. It drives the enables for the CPU clock, the peripheral clock, the primary oscillator and the internal RC oscillator, and it reports whether the primary oscillator is ready.

Three things can end a low-power state: an interrupt that is both flagged and enabled, a reset request, or a watchdog time-out. After any such wake event the block waits a fixed number of preparation cycles before the CPU clock returns. It also waits for the oscillator start-up timer, but only when execution resumes on a primary oscillator that was stopped and is not an external clock input. The block contains the watchdog counter and its postscaler. A time-out while code runs pulses a device-reset request instead of waking the part. A one-cycle take-vector flag tells the core whether to branch to the interrupt vector when execution resumes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Run (mode 0), the CPU and peripheral clocks are enabled, clock select is 2'b10 (internal), idle-enable is 0, and the primary oscillator is off and not ready.
- R2: A sleep strobe in Run moves to Idle (mode 1: CPU clock off, peripheral clock on) when idle-enable is 1, and to Sleep (mode 2: both clocks off) when it is 0. Mode 3 is the wake wait.
- R3: Clock select 2'b00 picks the primary oscillator and any other value picks the internal one. The primary oscillator is enabled when it is selected and the mode is not Sleep. The ready flag is low whenever the primary oscillator is off. It rises OST_CYC cycles after the oscillator starts, or one cycle after it starts in external-clock mode.
- R4: A low-power state is left only by a reset request, a watchdog time-out, or an interrupt whose flag bit and enable bit are both 1. A flag whose enable is 0 is ignored.
- R5: The CPU clock returns WAKE_CYC cycles after the wake event when no start-up wait is needed. During the wait the peripheral clock and the internal oscillator are on.
- R6: On resume, take_vector pulses for one cycle if the wake was caused by an interrupt and the global interrupt enable was 1 at the wake event. Otherwise it stays 0.
- R7: With the watchdog enabled, it times out WDT_BASE*WDT_POST cycles after it was last cleared. A time-out in Run pulses sys_reset. A time-out in Idle or Sleep causes a wake and does not pulse sys_reset.
- R8: The watchdog restarts on an accepted sleep strobe, on the clear strobe, and on loss of the clock while the clock monitor is enabled. A clock-loss pulse while the monitor is disabled has no effect.
- R9: A reset request forces clock select to 2'b10 and starts a wake wait from any mode, including Run. It leaves idle-enable unchanged.
- R10: A wake from Sleep onto a stopped primary oscillator that is not in external-clock mode resumes only after the oscillator is ready. A wake from Idle with the primary oscillator selected, or with external-clock mode set, resumes after WAKE_CYC cycles.
- R11: A wake caused by an interrupt or by the watchdog leaves clock select and idle-enable unchanged.
- R12: In Sleep the internal oscillator stays enabled if and only if the watchdog or the clock monitor is enabled.
- R13: Wake sources that arrive in the same cycle are ranked reset first, watchdog second, interrupt last. A lower-ranked source that coincides with a higher one never produces take_vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slp_stb | input | 1 | Sleep instruction strobe |
| clrwdt_stb | input | 1 | Clear-watchdog strobe |
| cfg_wr | input | 1 | Write idle-enable and clock select (accepted in Run) |
| cfg_idle_en | input | 1 | New idle-enable value |
| cfg_clk_sel | input | 2 | New clock select value |
| ext_clk_mode | input | 1 | Primary source is an external clock input |
| irq_flag | input | IRQ_N | Interrupt flag bits |
| irq_en | input | IRQ_N | Interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| rst_req | input | 1 | Reset request |
| wdt_en | input | 1 | Watchdog enable |
| fscm_en | input | 1 | Clock monitor enable |
| clk_lost | input | 1 | Selected clock lost |
| mode | output | 2 | 0 Run, 1 Idle, 2 Sleep, 3 wake wait |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| posc_en | output | 1 | Primary oscillator enable |
| intrc_en | output | 1 | Internal oscillator enable |
| osc_ready | output | 1 | Primary oscillator ready |
| take_vector | output | 1 | Branch to interrupt vector on resume |
| sys_reset | output | 1 | Device reset pulse from watchdog |
| idle_en | output | 1 | Current idle-enable bit |
| clk_sel | output | 2 | Current clock select |

## Verification
The hardest case to reach is two wake sources landing in the same cycle. The bench reaches it by counting the watchdog period from the sleep strobe, which clears the watchdog. It then raises an interrupt flag in the exact cycle before the predicted time-out, and separately raises a reset request together with an interrupt while in Sleep. A swept loop covers every combination of clock select, idle-enable, external-clock mode and global enable. The expected resume latency for each case is computed from WAKE_CYC and OST_CYC.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int IRQ_N    = 8,
  parameter int WAKE_CYC = 4,
  parameter int OST_CYC  = 1024,
  parameter int WDT_BASE = 128,
  parameter int WDT_POST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_stb,
  input  logic             clrwdt_stb,
  input  logic             cfg_wr,
  input  logic             cfg_idle_en,
  input  logic [1:0]       cfg_clk_sel,
  input  logic             ext_clk_mode,
  input  logic [IRQ_N-1:0] irq_flag,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             gie,
  input  logic             rst_req,
  input  logic             wdt_en,
  input  logic             fscm_en,
  input  logic             clk_lost,
  output logic [1:0]       mode,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             posc_en,
  output logic             intrc_en,
  output logic             osc_ready,
  output logic             take_vector,
  output logic             sys_reset,
  output logic             idle_en,
  output logic [1:0]       clk_sel
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);
  localparam int OS_W = $clog2(OST_CYC + 1);
  localparam int WB_W = $clog2(WDT_BASE + 1);
  localparam int WP_W = $clog2(WDT_POST + 1);
  localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYC - 1);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OST_CYC - 1);
  localparam logic [WB_W-1:0] WB_LAST = WB_W'(WDT_BASE - 1);
  localparam logic [WP_W-1:0] WP_LAST = WP_W'(WDT_POST - 1);
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_SLEEP = 2'd2, M_WAKE = 2'd3;
  localparam logic [1:0] SEL_INT = 2'b10;

  logic [1:0]      st;
  logic [WK_W-1:0] wk_cnt;
  logic [OS_W-1:0] ost_cnt;
  logic [WB_W-1:0] wb_cnt;
  logic [WP_W-1:0] wp_cnt;
  logic            rdy_q;
  logic            vec_pend;

  wire low_pwr  = (st == M_IDLE) || (st == M_SLEEP);
  wire pri_sel  = (clk_sel == 2'b00);
  wire irq_hit  = |(irq_flag & irq_en);
  wire wdt_clr  = !wdt_en || (slp_stb && st == M_RUN) || clrwdt_stb || (fscm_en && clk_lost);
  wire wdt_to   = !wdt_clr && (wb_cnt == WB_LAST) && (wp_cnt == WP_LAST);
  wire wake_ev  = low_pwr && (wdt_to || irq_hit);
  wire irq_wake = wake_ev && !wdt_to;
  wire wk_done  = (wk_cnt == WK_LAST);
  wire osc_ok   = !pri_sel || osc_ready;
  wire resume   = (st == M_WAKE) && wk_done && osc_ok && !rst_req;

  assign mode       = st;
  assign cpu_clk_en = (st == M_RUN);
  assign per_clk_en = (st != M_SLEEP);
  assign posc_en    = pri_sel && (st != M_SLEEP);
  assign osc_ready  = rdy_q && posc_en;
  assign intrc_en   = wdt_en || fscm_en || (st == M_WAKE) || (!pri_sel && st != M_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_RUN;
      wk_cnt   <= '0;
      vec_pend <= 1'b0;
    end else if (rst_req) begin
      st       <= M_WAKE;
      wk_cnt   <= '0;
      vec_pend <= 1'b0;
    end else begin
      case (st)
        M_RUN:   if (slp_stb) st <= idle_en ? M_IDLE : M_SLEEP;
        M_IDLE, M_SLEEP:
          if (wake_ev) begin
            st       <= M_WAKE;
            wk_cnt   <= '0;
            vec_pend <= irq_wake && gie;
          end
        default: begin
          if (!wk_done) wk_cnt <= wk_cnt + 1'b1;
          else if (osc_ok) st <= M_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_vector <= 1'b0;
      sys_reset   <= 1'b0;
    end else begin
      take_vector <= resume && vec_pend;
      sys_reset   <= wdt_to && (st == M_RUN) && !rst_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel <= SEL_INT;
      idle_en <= 1'b0;
    end else if (rst_req) begin
      clk_sel <= SEL_INT;
    end else if (cfg_wr && st == M_RUN) begin
      clk_sel <= cfg_clk_sel;
      idle_en <= cfg_idle_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      ost_cnt <= '0;
    end else if (!posc_en) begin
      rdy_q   <= 1'b0;
      ost_cnt <= '0;
    end else if (!rdy_q) begin
      if (ext_clk_mode || ost_cnt == OS_LAST) rdy_q <= 1'b1;
      else ost_cnt <= ost_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_cnt <= '0;
      wp_cnt <= '0;
    end else if (wdt_clr) begin
      wb_cnt <= '0;
      wp_cnt <= '0;
    end else if (wb_cnt == WB_LAST) begin
      wb_cnt <= '0;
      wp_cnt <= (wp_cnt == WP_LAST) ? '0 : wp_cnt + 1'b1;
    end else begin
      wb_cnt <= wb_cnt + 1'b1;
    end
  end

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SLEEP && $past(st) == M_RUN) |-> $past(slp_stb && !idle_en));
  a_r3_ready_with_posc: assert property (@(posedge clk) disable iff (!rst_n)
    osc_ready |-> $past(posc_en));
  a_r4_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_WAKE && $past(low_pwr)) |-> $past(rst_req || wdt_to || irq_hit));
  a_r5_resume_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_RUN && $past(st) == M_WAKE) |-> $past(wk_done));
  a_r6_vector_at_resume: assert property (@(posedge clk) disable iff (!rst_n)
    take_vector |-> (cpu_clk_en && $past(st) == M_WAKE));
  a_r7_reset_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> $past(st) == M_RUN);
  a_r11_wake_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_WAKE && $past(low_pwr) && !$past(rst_req)) |-> ($stable(clk_sel) && $stable(idle_en)));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int N = 4, W = 4, OST = 16, WB = 4, WP = 3, BP = WB * WP;

  logic clk = 0, rst_n = 0;
  logic slp_stb = 0, clrwdt_stb = 0, cfg_wr = 0, cfg_idle_en = 0, ext_clk_mode = 0;
  logic [1:0] cfg_clk_sel = 2'b10;
  logic [N-1:0] irq_flag = '0, irq_en = '0;
  logic gie = 0, rst_req = 0, wdt_en = 0, fscm_en = 0, clk_lost = 0;
  logic [1:0] mode, clk_sel;
  logic cpu_clk_en, per_clk_en, posc_en, intrc_en, osc_ready, take_vector, sys_reset, idle_en;
  int errors = 0, checks = 0, wd_bad = 0;

  pwr_mode_ctrl #(.IRQ_N(N), .WAKE_CYC(W), .OST_CYC(OST), .WDT_BASE(WB), .WDT_POST(WP)) u_pwr_mode_ctrl (
    .clk, .rst_n, .slp_stb, .clrwdt_stb, .cfg_wr, .cfg_idle_en, .cfg_clk_sel, .ext_clk_mode,
    .irq_flag, .irq_en, .gie, .rst_req, .wdt_en, .fscm_en, .clk_lost, .mode, .cpu_clk_en,
    .per_clk_en, .posc_en, .intrc_en, .osc_ready, .take_vector, .sys_reset, .idle_en, .clk_sel);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sleep_now();
    slp_stb = 1; tick(); slp_stb = 0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic idl);
    cfg_clk_sel = sel; cfg_idle_en = idl; cfg_wr = 1; tick(); cfg_wr = 0;
    repeat (20) tick();
  endtask

  task automatic wait_cpu(output int n, output int vec, output int rst_seen);
    n = 0; vec = 0; rst_seen = 0;
    while (!cpu_clk_en && n < 100) begin
      tick(); n++;
      if (mode == 2'd3 && !(per_clk_en && intrc_en)) wd_bad++;
      if (sys_reset) rst_seen = 1;
    end
    vec = take_vector;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, vec, rs;
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 mode", mode, 0); chk("R1 cpu", cpu_clk_en, 1); chk("R1 per", per_clk_en, 1);
    chk("R1 sel", clk_sel, 2); chk("R1 idle", idle_en, 0);
    chk("R1 posc", posc_en, 0); chk("R1 ready", osc_ready, 0);

    // R4 sweep: line x enable mask, waking from Sleep
    for (int i = 0; i < N; i++)
      for (int m = 0; m < (1 << N); m++) begin
        sleep_now();
        irq_flag = N'(1 << i); irq_en = N'(m);
        repeat (3) tick();
        chk($sformatf("R4 line%0d mask%0d", i, m), mode, m[i] ? 3 : 2);
        irq_en = N'(1 << i);
        wait_cpu(n, vec, rs);
        irq_flag = '0; irq_en = '0; tick();
      end

    // R3 start-up timer from Run
    ext_clk_mode = 0;
    cfg_clk_sel = 2'b00; cfg_idle_en = 0; cfg_wr = 1; tick(); cfg_wr = 0;
    chk("R3 posc on", posc_en, 1);
    n = 0;
    while (!osc_ready && n < 100) begin tick(); n++; end
    chk("R3 ost count", n, OST);
    cfg_clk_sel = 2'b10; cfg_wr = 1; tick(); cfg_wr = 0;
    chk("R3 ready cleared", osc_ready, 0); chk("R3 posc off", posc_en, 0);

    // R2 R5 R6 R10 R11 R12 sweep over sel, idle, ext, gie
    for (int c = 0; c < 16; c++) begin
      logic pri, idl, ext, g;
      int lat;
      pri = c[0]; idl = c[1]; ext = c[2]; g = c[3];
      ext_clk_mode = ext;
      cfg(pri ? 2'b00 : 2'b10, idl);
      sleep_now();
      chk($sformatf("R2 mode c%0d", c), mode, idl ? 1 : 2);
      chk($sformatf("R2 cpu c%0d", c), cpu_clk_en, 0);
      chk($sformatf("R2 per c%0d", c), per_clk_en, idl);
      chk($sformatf("R3 posc c%0d", c), posc_en, pri && idl);
      chk($sformatf("R12 intrc c%0d", c), intrc_en, !pri && idl);
      gie = g; irq_flag = 1; irq_en = 1;
      wait_cpu(n, vec, rs);
      lat = (pri && !idl && !ext) ? OST + 1 : W;
      chk($sformatf("R10 R5 latency c%0d", c), n, lat + 1);
      chk($sformatf("R6 vector c%0d", c), vec, g);
      chk($sformatf("R11 sel c%0d", c), clk_sel, pri ? 0 : 2);
      chk($sformatf("R11 idle c%0d", c), idle_en, idl);
      irq_flag = 0; irq_en = 0; gie = 0; tick();
      chk($sformatf("R6 one pulse c%0d", c), take_vector, 0);
    end
    chk("R5 clocks during wait", wd_bad, 0);
    ext_clk_mode = 0;
    cfg(2'b10, 0);

    // R7 R8 watchdog in Run
    wdt_en = 1; clrwdt_stb = 1; tick(); clrwdt_stb = 0;
    n = 0; while (!sys_reset && n < 100) begin tick(); n++; end
    chk("R7 period", n, BP);
    clrwdt_stb = 1; tick(); clrwdt_stb = 0;
    repeat (8) tick();
    clrwdt_stb = 1; tick(); clrwdt_stb = 0;
    n = 0; while (!sys_reset && n < 100) begin tick(); n++; end
    chk("R8 clear strobe restarts", n, BP);
    clrwdt_stb = 1; tick(); clrwdt_stb = 0;
    repeat (5) tick();
    fscm_en = 1; clk_lost = 1; tick(); clk_lost = 0; fscm_en = 0;
    n = 0; while (!sys_reset && n < 100) begin tick(); n++; end
    chk("R8 clock loss restarts", n, BP);
    clrwdt_stb = 1; tick(); clrwdt_stb = 0;
    repeat (5) tick();
    clk_lost = 1; tick(); clk_lost = 0;
    n = 0; while (!sys_reset && n < 100) begin tick(); n++; end
    chk("R8 loss ignored without monitor", n, BP - 6);

    // R7 wake from Sleep by watchdog, sleep strobe clears it
    clrwdt_stb = 1; repeat (5) tick(); clrwdt_stb = 0;
    sleep_now();
    chk("R12 intrc in sleep with wdt", intrc_en, 1);
    wait_cpu(n, vec, rs);
    wdt_en = 0;
    chk("R7 wake latency", n, BP + W);
    chk("R7 no reset on wake", rs, 0);
    chk("R7 no vector", vec, 0);
    tick();

    // R13 watchdog and interrupt together
    wdt_en = 1; gie = 1; irq_en = 1;
    sleep_now();
    repeat (BP - 1) tick();
    irq_flag = 1;
    wait_cpu(n, vec, rs);
    wdt_en = 0; irq_flag = 0;
    chk("R13 wdt over irq latency", n, W + 1);
    chk("R13 wdt over irq vector", vec, 0);
    tick();

    // R9 R13 reset with interrupt in Sleep on primary
    cfg(2'b00, 0);
    sleep_now();
    irq_flag = 1; rst_req = 1; tick(); rst_req = 0;
    chk("R9 sel forced", clk_sel, 2);
    chk("R9 wake wait", mode, 3);
    wait_cpu(n, vec, rs);
    chk("R13 reset over irq vector", vec, 0);
    irq_flag = 0; irq_en = 0; gie = 0; tick();

    // R9 reset in Run
    cfg(2'b00, 1);
    rst_req = 1; tick(); rst_req = 0;
    chk("R9 cpu stops", cpu_clk_en, 0);
    chk("R9 sel forced run", clk_sel, 2);
    chk("R9 idle kept", idle_en, 1);
    wait_cpu(n, vec, rs);
    chk("R9 resume delay", n, W);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule